// File: doc/BRIEF.md
# Five-Source Interrupt Flag Controller

This block keeps the pending-request state and the mask for five interrupt sources of a small processor system and turns them into a single level interrupt line. Peripherals raise one-cycle set pulses. The processor reads and writes a pending-flag byte and an enable byte through one byte-wide port with a one-bit register select.

A source becomes pending when its pulse arrives, whether or not it is enabled. The interrupt line is high while at least one pending source is also enabled. The line is recomputed from the next-state values on every register write as well as on every pulse. Software can therefore raise the line by enabling a source that is already waiting. It can drop the line by clearing flags or enables. Flag bit positions are fixed: 0 vertical blank, 1 display status, 2 timer overflow, 3 serial transfer, 4 keypad. A pulse on `src_pulse[i]` targets flag bit i.

Top module: `irqf_ctrl`

## Requirements
- R1: After reset the flag byte reads 0xE0, the enable byte reads 0x00 and `irq` is low.
- R2: A write with `reg_sel`=0 stores `wr_data[4:0]` into flag bits 4..0. Flag bits 7..5 always read as 1, whatever was written.
- R3: A write with `reg_sel`=1 stores all 8 bits of `wr_data` into the enable byte, and they read back unchanged.
- R4: A high `src_pulse[i]` sets flag bit i at the next clock edge, whatever the state of enable bit i. A set flag stays set until a flag write clears it.
- R5: `irq` is registered. After every clock edge it equals the OR over i in 0..4 of (flag bit i AND enable bit i), using the register values just loaded at that edge.
- R6: Writing the enable byte so that it covers an already pending flag raises `irq` at the same edge that loads the enable byte.
- R7: Writing the flag byte so that no enabled flag remains set lowers `irq` at the same edge.
- R8: When a pulse and a flag write fall in the same cycle, each pulsed bit ends up set. Each bit without a pulse takes the written value.
- R9: Enable bits 7..5 are stored but never affect `irq`.
- R10: `rd_data` is combinational. It shows the flag byte when `reg_sel`=0 and the enable byte when `reg_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 flag byte, 1 enable byte |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| src_pulse | input | 5 | Per-source set pulses, bit i sets flag i |
| irq | output | 1 | Level interrupt request |

## Verification
A table of writes and pulses walks the flag and enable state through three kinds of cases. The first is pulses on disabled sources, which separates latching from masking. The second is enabling an already-pending source, which separates immediate re-evaluation from evaluation only on new pulses. The third is flag writes that leave only disabled bits set, which shows whether software can lower the line. Same-cycle pulse and flag-write entries mix pulsed and non-pulsed bits, so a controller that lets the write win, or that ORs the write into the flags, gives a different byte. Enable values with only bits 7..5 set show whether the mask width is wrong. Directed cases check the reset state, reset in the middle of a run, and the exact edge at which `irq` changes.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int unsigned IRQF_NUM_SRC = 5;
    localparam int unsigned IRQF_DATA_W  = 8;

    typedef enum logic {
        SEL_FLAG   = 1'b0,
        SEL_ENABLE = 1'b1
    } irqf_sel_e;

endpackage

// File: rtl/irqf_flag_reg.sv
module irqf_flag_reg #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] set_pulse,
    output logic [NSRC-1:0] flag_d,
    output logic [NSRC-1:0] flag_q
);

    typedef struct packed {
        logic [NSRC-1:0] flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    // Per bit: a pulse forces 1; otherwise a write replaces the bit; otherwise hold.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (set_pulse[i]) begin
                st_d.flag[i] = 1'b1;
            end else if (wr_en) begin
                st_d.flag[i] = wdata[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_d = st_d.flag;
    assign flag_q = st_q.flag;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        p_pulse_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_pulse[g] |=> flag_q[g]);
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !wr_en && !set_pulse[g]) |=> flag_q[g]);
        p_pulse_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (set_pulse[g] && wr_en && !wdata[g]) |=> flag_q[g]);
    end

    p_flag_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_pulse == '0) |=> flag_q == $past(wdata));

endmodule

// File: rtl/irqf_enable_reg.sv
module irqf_enable_reg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en_d,
    output logic [DW-1:0] en_q
);

    typedef struct packed {
        logic [DW-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_d = st_d.en;
    assign en_q = st_q.en;

    p_en_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q == $past(wdata));

    p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/irqf_irq_eval.sv
module irqf_irq_eval #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flag_nxt,
    input  logic [NSRC-1:0] en_nxt,
    output logic            irq_q
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t      st_d, st_q;
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_hit
        assign hit[g] = flag_nxt[g] & en_nxt[g];
    end

    // Evaluated from next-state values so the line moves at the same edge as the registers.
    always_comb begin
        st_d     = st_q;
        st_d.irq = |hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_q = st_q.irq;

endmodule

// File: rtl/irqf_ctrl.sv
module irqf_ctrl #(
    parameter int unsigned NUM_SRC = irqf_pkg::IRQF_NUM_SRC,
    parameter int unsigned DATA_W  = irqf_pkg::IRQF_DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic               irq
);
    import irqf_pkg::*;

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic               wr_flag, wr_enable;
    logic [NUM_SRC-1:0] flag_d, flag_q;
    logic [DATA_W-1:0]  en_d, en_q;
    logic [DATA_W-1:0]  flag_view;

    assign wr_flag   = wr_en && (irqf_sel_e'(reg_sel) == SEL_FLAG);
    assign wr_enable = wr_en && (irqf_sel_e'(reg_sel) == SEL_ENABLE);

    irqf_flag_reg #(.NSRC(NUM_SRC)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_flag),
        .wdata     (wr_data[NUM_SRC-1:0]),
        .set_pulse (src_pulse),
        .flag_d    (flag_d),
        .flag_q    (flag_q)
    );

    irqf_enable_reg #(.DW(DATA_W)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_enable),
        .wdata (wr_data),
        .en_d  (en_d),
        .en_q  (en_q)
    );

    irqf_irq_eval #(.NSRC(NUM_SRC)) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_nxt (flag_d),
        .en_nxt   (en_d[NUM_SRC-1:0]),
        .irq_q    (irq)
    );

    // Unused flag positions read as ones.
    assign flag_view = {{PAD_W{1'b1}}, flag_q};

    always_comb begin
        rd_data = (irqf_sel_e'(reg_sel) == SEL_ENABLE) ? en_q : flag_view;
    end

    p_irq_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(flag_q & en_q[NUM_SRC-1:0]));

    p_enable_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && src_pulse == '0 && |(flag_q & wr_data[NUM_SRC-1:0])) |=> irq);

    p_flag_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !wr_enable && src_pulse == '0 &&
         (wr_data[NUM_SRC-1:0] & en_q[NUM_SRC-1:0]) == '0) |=> !irq);

    p_upper_en_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q[NUM_SRC-1:0]) == '0) |-> !irq);

    p_pad_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_view[DATA_W-1:NUM_SRC] == {PAD_W{1'b1}});

endmodule

// File: tb/irqf_ctrl_tb.sv
`timescale 1ns/1ps
module irqf_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [4:0] src_pulse = 5'h00;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irqf_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .src_pulse (src_pulse),
        .irq       (irq)
    );

    typedef struct packed {
        logic       sel;
        logic       wr;
        logic [7:0] wd;
        logic [4:0] pl;
        logic [7:0] exp_flag;
        logic [7:0] exp_en;
        logic       exp_irq;
    } vec_t;

    // State carries from entry to entry; expected values are read-back bytes.
    localparam vec_t TBL [13] = '{
        '{1'b0, 1'b0, 8'h00, 5'h01, 8'hE1, 8'h00, 1'b0}, // R4 pulse on disabled source
        '{1'b1, 1'b1, 8'h01, 5'h00, 8'hE1, 8'h01, 1'b1}, // R6 enable pending source
        '{1'b0, 1'b1, 8'h00, 5'h00, 8'hE0, 8'h01, 1'b0}, // R7 clear flag drops irq
        '{1'b1, 1'b1, 8'hE0, 5'h00, 8'hE0, 8'hE0, 1'b0}, // R3 upper enable bits stored
        '{1'b0, 1'b0, 8'h00, 5'h1F, 8'hFF, 8'hE0, 1'b0}, // R9 upper enables ignored
        '{1'b1, 1'b1, 8'h10, 5'h00, 8'hFF, 8'h10, 1'b1}, // R6 keypad enable
        '{1'b0, 1'b1, 8'h0F, 5'h00, 8'hEF, 8'h10, 1'b0}, // R7 only disabled flags left
        '{1'b0, 1'b1, 8'h00, 5'h10, 8'hF0, 8'h10, 1'b1}, // R8 pulse beats write-zero
        '{1'b0, 1'b1, 8'h05, 5'h02, 8'hE7, 8'h10, 1'b0}, // R8 mix of pulsed and written
        '{1'b1, 1'b1, 8'hFF, 5'h00, 8'hE7, 8'hFF, 1'b1}, // R5 all enabled
        '{1'b0, 1'b1, 8'hFF, 5'h00, 8'hFF, 8'hFF, 1'b1}, // R2 write all ones
        '{1'b0, 1'b1, 8'hE0, 5'h00, 8'hE0, 8'hFF, 1'b0}, // R2 upper write bits ignored
        '{1'b1, 1'b1, 8'h04, 5'h04, 8'hE4, 8'h04, 1'b1}  // R5 enable write with pulse
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic read_back(input string req, input logic [7:0] ef,
                             input logic [7:0] ee, input logic ei);
        reg_sel = 1'b0;
        #1;
        chk({req, " flag byte"}, rd_data, ef);
        reg_sel = 1'b1;
        #1;
        chk({req, " enable byte"}, rd_data, ee);
        chk({req, " irq"}, {7'd0, irq}, {7'd0, ei});
    endtask

    task automatic step(input logic sel, input logic wr, input logic [7:0] wd,
                        input logic [4:0] pl);
        @(negedge clk);
        reg_sel   = sel;
        wr_en     = wr;
        wr_data   = wd;
        src_pulse = pl;
        @(negedge clk);
        wr_en     = 1'b0;
        src_pulse = 5'h00;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        read_back("R1 reset", 8'hE0, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 13; k++) begin
            step(TBL[k].sel, TBL[k].wr, TBL[k].wd, TBL[k].pl);
            read_back($sformatf("vector %0d", k), TBL[k].exp_flag, TBL[k].exp_en, TBL[k].exp_irq);
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        read_back("R1 mid-run reset", 8'hE0, 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: irq changes at the edge that loads the pulse, not before
        step(1'b1, 1'b1, 8'h08, 5'h00);
        @(negedge clk);
        src_pulse = 5'h08;
        #1;
        chk("R5 irq before edge", {7'd0, irq}, 8'h00);
        @(posedge clk);
        #1;
        chk("R5 irq after edge", {7'd0, irq}, 8'h01);
        src_pulse = 5'h00;

        // R10: read mux follows the select with no clock
        reg_sel = 1'b0;
        #1;
        chk("R10 select flag", rd_data, 8'hE8);
        reg_sel = 1'b1;
        #1;
        chk("R10 select enable", rd_data, 8'h08);

        // R4: flag stays set over idle cycles
        repeat (4) @(negedge clk);
        read_back("R4 sticky", 8'hE8, 8'h08, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule